// File: doc/BRIEF.md
# Dual-Channel Audio Test-Tone Generator

This block produces a pair of 32-bit audio samples, channel A and channel B, once for every sample-enable pulse. Each channel picks one of two sources on its own: a 32-bit constant held in a register for that channel, or a pseudo-random noise word. The noise word comes from a single 16-bit linear feedback shift register that both channels share. Channel B can be delayed by a programmable number of samples relative to channel A. A summing option replaces channel A with the saturated signed sum of A and the (delayed) B. Everything runs in one clock domain. A one-cycle enable pulse marks the sample rate.

A small controller watches the mode inputs. These are the two source selects, the sum option and the delay. It has three states. ST_FLUSH is the reset state and is also entered on any mode change. The next sample pulse taken in ST_FLUSH is dropped: no valid flag, and the outputs hold. On that pulse the controller moves to ST_FILL if the delay is non-zero, or straight to ST_RUN if the delay is zero. In ST_FILL, channel B outputs zero while the delay line fills. After as many valid samples as the delay value, ST_FILL moves to ST_RUN. ST_RUN is steady operation. A mode change seen in ST_FILL or ST_RUN moves the controller back to ST_FLUSH. If the change arrives in the same cycle as a pulse, that pulse is the dropped one. The controller then goes directly to ST_FILL or ST_RUN.

Top module: `dual_tone_gen`

## Requirements
- R1: The noise register is a Fibonacci shift register for x^16+x^14+x^13+x^11+1. It shifts left, taking bit15^bit13^bit12^bit10 into bit 0. It holds 0x0001 after reset and never holds zero.
- R2: The noise register steps exactly once per sample-enable pulse, dropped pulses included, and holds between pulses.
- R3: A noise sample is {h,h}, where h = 0x4000 minus the register value modulo 2^16. The register value used is the one before that pulse's step. When both channels select noise, both carry the same word.
- R4: A channel whose noise select is 0 outputs its own 32-bit constant input. A noise select of 1 picks noise.
- R5: With delay D (0..255), channel B on a valid sample equals the undelayed B source from D valid samples earlier. The first D valid samples after a dropped pulse give 0 on B. D=0 means no delay.
- R6: With the sum option on, channel A is the signed 32-bit sum of A and the delayed B. The sum clamps to 0x7FFFFFFF on positive overflow and to 0x80000000 on negative overflow. B is unchanged.
- R7: The outputs update at the clock edge where the sample enable is high. The valid flag is high for exactly the one following cycle. After reset the outputs are 0 and the flag is low.
- R8: After reset, or after a change of either source select, the sum option or the delay, the next sample pulse is dropped. A dropped pulse leaves the flag low and the outputs unchanged, and restarts the delay fill.
- R9: A change of either constant value takes effect on the next pulse without dropping it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sample-rate enable pulse |
| noise_sel_a | input | 1 | Channel A source: 1 noise, 0 constant |
| noise_sel_b | input | 1 | Channel B source: 1 noise, 0 constant |
| const_a | input | 32 | Channel A constant value |
| const_b | input | 32 | Channel B constant value |
| delay_b | input | 8 | Channel B delay in samples |
| sum_on | input | 1 | Put saturated A+B on channel A |
| samp_a | output | 32 | Channel A sample |
| samp_b | output | 32 | Channel B sample |
| samp_vld | output | 1 | Sample valid, one cycle per accepted pulse |

## Verification
Constants with distinct values per channel show that each channel reads its own register and that a source select routes correctly. Noise runs with uneven idle gaps between pulses are compared against an independent model of the register. This separates stepping per pulse from stepping per clock, and checks that the dropped pulse is counted as a step. Changing the B constant on every pulse under a delay exposes the exact sample offset and the zero fill, without any mode change getting in the way. Sums near both ends of the signed range tell saturation apart from wrap-around.

// File: rtl/tg_pkg.sv
package tg_pkg;

    localparam int SAMPLE_W = 32;
    localparam int HALF_W   = SAMPLE_W / 2;
    localparam int DLY_W    = 8;

    typedef enum logic [1:0] {
        ST_FLUSH = 2'd0,
        ST_FILL  = 2'd1,
        ST_RUN   = 2'd2
    } tg_state_t;

    typedef struct packed {
        logic             noise_a;
        logic             noise_b;
        logic             sum_on;
        logic [DLY_W-1:0] dly;
    } tg_cfg_t;

    function automatic logic [SAMPLE_W-1:0] sat_add(
        input logic [SAMPLE_W-1:0] x,
        input logic [SAMPLE_W-1:0] y
    );
        logic [SAMPLE_W:0] s;
        s = {x[SAMPLE_W-1], x} + {y[SAMPLE_W-1], y};
        if (s[SAMPLE_W] != s[SAMPLE_W-1])
            sat_add = s[SAMPLE_W] ? {1'b1, {(SAMPLE_W-1){1'b0}}}
                                  : {1'b0, {(SAMPLE_W-1){1'b1}}};
        else
            sat_add = s[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/tg_lfsr.sv
module tg_lfsr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] state
);
    logic fb;

    assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= W'(1);
        else if (step)
            state <= {state[W-2:0], fb};
    end

    assert_lfsr_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

    assert_lfsr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state));

endmodule

// File: rtl/tg_delay.sv
module tg_delay #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] dly,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;

    assign rp = wp - dly;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wp <= '0;
        else if (wr_en)
            wp <= wp + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wp] <= wr_data;
    end

    assign rd_data = (dly == '0) ? wr_data : mem[rp];

endmodule

// File: rtl/tg_ctrl.sv
module tg_ctrl
    import tg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      smp_en,
    input  tg_cfg_t   cfg_in,
    output tg_state_t st,
    output logic      drop
);
    tg_state_t        st_nx;
    tg_cfg_t          cfg_q;
    logic [DLY_W-1:0] fill;
    logic [DLY_W-1:0] fill_nx;
    logic             cfg_chg;

    assign cfg_chg = (cfg_in != cfg_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_FLUSH;
            fill  <= '0;
            cfg_q <= '0;
        end else begin
            st    <= st_nx;
            fill  <= fill_nx;
            cfg_q <= cfg_in;
        end
    end

    always_comb begin
        st_nx   = st;
        fill_nx = fill;
        drop    = 1'b0;
        unique case (st)
            ST_FLUSH: begin
                drop = 1'b1;
                if (smp_en) begin
                    fill_nx = '0;
                    st_nx   = (cfg_in.dly == '0) ? ST_RUN : ST_FILL;
                end
            end
            ST_FILL: begin
                drop = cfg_chg;
                if (smp_en && cfg_chg) begin
                    fill_nx = '0;
                    st_nx   = (cfg_in.dly == '0) ? ST_RUN : ST_FILL;
                end else if (cfg_chg) begin
                    st_nx = ST_FLUSH;
                end else if (smp_en) begin
                    if (fill == cfg_in.dly - DLY_W'(1))
                        st_nx = ST_RUN;
                    else
                        fill_nx = fill + DLY_W'(1);
                end
            end
            ST_RUN: begin
                drop = cfg_chg;
                if (smp_en && cfg_chg) begin
                    fill_nx = '0;
                    st_nx   = (cfg_in.dly == '0) ? ST_RUN : ST_FILL;
                end else if (cfg_chg) begin
                    st_nx = ST_FLUSH;
                end
            end
            default: st_nx = ST_FLUSH;
        endcase
    end

    assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL && !cfg_chg) |-> (fill < cfg_in.dly));

    assert_change_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_chg && !smp_en) |=> (st == ST_FLUSH));

endmodule

// File: rtl/dual_tone_gen.sv
module dual_tone_gen
    import tg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_en,
    input  logic                noise_sel_a,
    input  logic                noise_sel_b,
    input  logic [SAMPLE_W-1:0] const_a,
    input  logic [SAMPLE_W-1:0] const_b,
    input  logic [DLY_W-1:0]    delay_b,
    input  logic                sum_on,
    output logic [SAMPLE_W-1:0] samp_a,
    output logic [SAMPLE_W-1:0] samp_b,
    output logic                samp_vld
);
    tg_cfg_t             cfg;
    tg_state_t           st;
    logic                drop;
    logic [HALF_W-1:0]   lfsr_q;
    logic [HALF_W-1:0]   half;
    logic [SAMPLE_W-1:0] noise_w;
    logic [SAMPLE_W-1:0] raw_a;
    logic [SAMPLE_W-1:0] raw_b;
    logic [SAMPLE_W-1:0] del_b;
    logic [SAMPLE_W-1:0] out_b;
    logic [SAMPLE_W-1:0] out_a;
    logic                accept;

    assign cfg = '{noise_a: noise_sel_a, noise_b: noise_sel_b,
                   sum_on: sum_on, dly: delay_b};

    tg_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (smp_en),
        .cfg_in (cfg),
        .st     (st),
        .drop   (drop)
    );

    tg_lfsr #(.W(HALF_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (smp_en),
        .state (lfsr_q)
    );

    assign half    = HALF_W'(16'h4000) - lfsr_q;
    assign noise_w = {half, half};
    assign raw_a   = noise_sel_a ? noise_w : const_a;
    assign raw_b   = noise_sel_b ? noise_w : const_b;
    assign accept  = smp_en && !drop;

    tg_delay #(.DW(SAMPLE_W), .AW(DLY_W)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_data (raw_b),
        .dly     (delay_b),
        .rd_data (del_b)
    );

    assign out_b = (st == ST_FILL) ? '0 : del_b;
    assign out_a = sum_on ? sat_add(raw_a, out_b) : raw_a;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_a   <= '0;
            samp_b   <= '0;
            samp_vld <= 1'b0;
        end else begin
            samp_vld <= accept;
            if (accept) begin
                samp_a <= out_a;
                samp_b <= out_b;
            end
        end
    end

    assert_idle_novld_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> !samp_vld);

    assert_drop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && drop) |=> (!samp_vld && $stable(samp_a) && $stable(samp_b)));

    assert_fill_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st == ST_FILL) |=> (samp_b == '0));

    assert_sum_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sum_on && !raw_a[SAMPLE_W-1] && !out_b[SAMPLE_W-1])
        |=> !samp_a[SAMPLE_W-1]);

endmodule

// File: tb/dual_tone_gen_tb_top.sv
module dual_tone_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_en = 1'b0;
    logic        na = 1'b0, nb = 1'b0, son = 1'b0;
    logic [31:0] ca = '0, cb = '0;
    logic [7:0]  dly = '0;
    logic [31:0] sa, sb;
    logic        sv;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_lfsr = 16'h0001;
    logic [31:0] last_nz;

    always #5 clk = ~clk;

    dual_tone_gen dut_i (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en),
        .noise_sel_a(na), .noise_sel_b(nb),
        .const_a(ca), .const_b(cb), .delay_b(dly), .sum_on(son),
        .samp_a(sa), .samp_b(sb), .samp_vld(sv)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nz(input logic [15:0] s);
        logic [15:0] h;
        h = 16'h4000 - s;
        return {h, h};
    endfunction

    // one pulse; model noise word for this pulse and step model register
    task automatic pulse(input int gap);
        repeat (gap) @(negedge clk);
        last_nz = nz(m_lfsr);
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        smp_en = 1'b1;
        @(negedge clk);
        smp_en = 1'b0;
    endtask

    task automatic set_cfg(input logic a, input logic b, input logic s, input logic [7:0] d);
        @(negedge clk);
        na = a; nb = b; son = s; dly = d;
    endtask

    task automatic t_reset;
        logic [31:0] pa, pb;
        chk("R7 reset vld", {31'd0, sv}, 32'd0);
        chk("R7 reset a", sa, 32'd0);
        chk("R7 reset b", sb, 32'd0);
        pa = sa; pb = sb;
        pulse(1);
        chk("R8 first pulse dropped", {31'd0, sv}, 32'd0);
        chk("R8 dropped hold a", sa, pa);
        @(negedge clk);
        chk("R7 vld low between", {31'd0, sv}, 32'd0);
    endtask

    task automatic t_const;
        ca = 32'h1234_5678; cb = 32'hCAFE_0001;
        pulse(2);
        chk("R7 vld after pulse", {31'd0, sv}, 32'd1);
        chk("R4 const a", sa, 32'h1234_5678);
        chk("R4 const b", sb, 32'hCAFE_0001);
        @(negedge clk);
        chk("R7 vld one cycle", {31'd0, sv}, 32'd0);
        chk("R7 hold a", sa, 32'h1234_5678);
        ca = 32'h0000_0042;
        pulse(1);
        chk("R9 const change vld", {31'd0, sv}, 32'd1);
        chk("R9 const change a", sa, 32'h0000_0042);
    endtask

    task automatic t_noise;
        set_cfg(1'b1, 1'b1, 1'b0, 8'd0);
        pulse(2);
        chk("R8 mode change dropped", {31'd0, sv}, 32'd0);
        for (int k = 0; k < 6; k++) begin
            pulse((k % 2 == 0) ? 1 : 5);
            chk("R1 R2 R3 noise a", sa, last_nz);
            chk("R3 noise b shared", sb, last_nz);
        end
        set_cfg(1'b0, 1'b1, 1'b0, 8'd0);
        pulse(1);
        chk("R8 select change dropped", {31'd0, sv}, 32'd0);
        pulse(3);
        chk("R4 a const b noise a", sa, 32'h0000_0042);
        chk("R4 a const b noise b", sb, last_nz);
    endtask

    task automatic t_delay;
        ca = 32'd11;
        set_cfg(1'b0, 1'b0, 1'b0, 8'd3);
        pulse(2);
        chk("R8 delay change dropped", {31'd0, sv}, 32'd0);
        for (int k = 0; k < 7; k++) begin
            cb = 32'd100 + 32'(k);
            pulse(1);
            chk("R5 delay a", sa, 32'd11);
            chk("R5 delay b", sb, (k < 3) ? 32'd0 : 32'd100 + 32'(k - 3));
        end
        set_cfg(1'b0, 1'b0, 1'b0, 8'd1);
        pulse(1);
        chk("R8 delay refill dropped", {31'd0, sv}, 32'd0);
        for (int k = 0; k < 3; k++) begin
            cb = 32'd200 + 32'(k);
            pulse(2);
            chk("R5 delay1 b", sb, (k < 1) ? 32'd0 : 32'd200 + 32'(k - 1));
        end
    endtask

    task automatic t_sum;
        set_cfg(1'b0, 1'b0, 1'b1, 8'd0);
        pulse(2);
        chk("R8 sum change dropped", {31'd0, sv}, 32'd0);
        ca = 32'd5; cb = 32'd7;
        pulse(1);
        chk("R6 plain sum a", sa, 32'd12);
        chk("R6 sum b unchanged", sb, 32'd7);
        ca = 32'h7FFF_FFF0; cb = 32'h0000_0100;
        pulse(1);
        chk("R6 positive clamp", sa, 32'h7FFF_FFFF);
        ca = 32'h8000_0010; cb = 32'hFFFF_FF00;
        pulse(1);
        chk("R6 negative clamp", sa, 32'h8000_0000);
        ca = 32'h7FFF_FFFF; cb = 32'hFFFF_FFFF;
        pulse(1);
        chk("R6 mixed sign", sa, 32'h7FFF_FFFE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_const();
        t_noise();
        t_delay();
        t_sum();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule